// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synthesizable model of a synchronous burst static RAM with its control path, data path and a small internal array. On every rising clock edge it samples three chip selects, two address strobes (one meant for a processor and one for a cache controller), a burst step input, the write controls and the write data. From these it decides whether to open a new burst at the external address, step the burst to its next address, hold at the current address, or drop the selection. Writes are masked per byte lane. Each lane is eight data bits plus one parity bit.

Read data comes back through a two-register pipeline. The array word is captured on the edge that performs the read, and it appears at the outputs one edge later. The tristate bus is modelled as a registered data output plus a drive-enable output. The output enable acts on the drive-enable without waiting for the clock. A separate block generates the address sequence inside a burst. A static mode input selects linear or interleaved stepping. Because the array is written on the edge that samples the write, a read issued on the next edge returns the new contents.

Top module: `sbr_burst_sram`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_drive` is 0 and no burst is open. Step or hold cycles given before any strobe produce no read output.
- R2: A read performed on edge k appears on `rd_data` after edge k+1. `rd_drive` is 1 in that cycle if edge k+1 is not a write and `out_en_n` is 0.
- R3: A strobe (processor strobe with `sel_a_n`=0, or controller strobe) sampled while the device is not selected closes the burst. Later step or hold cycles perform no access until a new burst opens. The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0.
- R4: When `sel_a_n`=1, a low processor strobe is ignored, and the edge behaves as if that strobe were high.
- R5: The controller strobe opens a burst only while the processor strobe is high. The write controls sampled on that same edge choose between a write and a read at the external address.
- R6: A processor strobe while selected opens a read at the external address. The write controls on that edge have no effect on the array.
- R7: With both strobes high and a burst open, `step_n`=0 advances to the next burst address and `step_n`=1 repeats the current one. The chip selects are not examined on such edges.
- R8: With `interleave`=0, the two low address bits count up by one from the start value modulo 4, and the upper bits stay fixed.
- R9: With `interleave`=1, the two low address bits equal the start value XOR the step count (0,1,2,3).
- R10: `all_wr_n`=0 writes all lanes. Otherwise, `lane_wr_n`=0 writes each lane g whose `lane_sel_n[g]`=0, where lane g occupies `wdata[9g+8:9g]`. With no lane chosen, the cycle is a read.
- R11: A write on edge k forces `rd_drive` to 0 after that edge, whatever the level of `out_en_n`. While read data is pending, `out_en_n`=1 forces `rd_drive` low without a clock edge.
- R12: A read directly following a write to the same word returns the written lanes with the new data and leaves the other lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | External word address, AW = clog2(DEPTH) |
| sel_a_n | input | 1 | Active-low chip select that also gates the processor strobe |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write of every lane, active low |
| lane_wr_n | input | 1 | Enables the per-lane write selects, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | LANES*9 | Write data, 9 bits per lane |
| rd_data | output | LANES*9 | Registered read data |
| rd_drive | output | 1 | Bus drive enable for rd_data |

## Verification
The bench builds the block with DEPTH=64, LANES=4 and BURST_W=2. The shallow array lets short addresses reach both the wrap of a four-word burst group and a second, independent word. Four lanes make it possible to write a single middle lane and then observe that its neighbours on both sides are untouched. With the two-bit burst counter, both sequence orders complete a full wrap within a handful of cycles, and start offsets can be chosen where the linear and interleaved orders visibly differ.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_STEP,
        CMD_OPEN_RD,
        CMD_OPEN_CTL,
        CMD_DROP
    } sbr_cmd_e;

    localparam int unsigned LANE_BITS = 9;

endpackage

// File: rtl/sbr_cmd_decode.sv
module sbr_cmd_decode
    import sbr_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             proc_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output sbr_cmd_e         cmd,
    output logic [LANES-1:0] wr_lanes,
    output logic             wr_req
);

    logic selected;
    logic proc_live;

    always_comb begin
        selected  = !sel_a_n && sel_b && !sel_c_n;
        // the processor strobe only counts while the first select is low
        proc_live = !proc_stb_n && !sel_a_n;

        if (proc_live) begin
            cmd = selected ? CMD_OPEN_RD : CMD_DROP;
        end else if (!ctrl_stb_n) begin
            cmd = selected ? CMD_OPEN_CTL : CMD_DROP;
        end else begin
            cmd = step_n ? CMD_HOLD : CMD_STEP;
        end

        if (!all_wr_n) begin
            wr_lanes = '1;
        end else if (!lane_wr_n) begin
            wr_lanes = ~lane_sel_n;
        end else begin
            wr_lanes = '0;
        end
        wr_req = |wr_lanes;
    end

endmodule

// File: rtl/sbr_burst_seq.sv
module sbr_burst_seq #(
    parameter int unsigned BURST_W = 2
) (
    input  logic [BURST_W-1:0] start_lo,
    input  logic [BURST_W-1:0] count,
    input  logic               interleave,
    output logic [BURST_W-1:0] lo
);

    always_comb begin
        if (interleave) begin
            lo = start_lo ^ count;
        end else begin
            lo = start_lo + count;
        end
    end

endmodule

// File: rtl/sbr_lane_array.sv
module sbr_lane_array #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g]) begin
                bank[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[addr];
    end

endmodule

// File: rtl/sbr_burst_sram.sv
module sbr_burst_sram
    import sbr_pkg::*;
#(
    parameter int unsigned DEPTH   = 1024,
    parameter int unsigned LANES   = 4,
    parameter int unsigned BURST_W = 2,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned DW     = LANES * LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             proc_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             out_en_n,
    input  logic             interleave,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_data,
    output logic             rd_drive
);

    typedef struct packed {
        logic               active;
        logic [AW-1:0]      base;
        logic [BURST_W-1:0] count;
    } ctl_t;

    typedef struct packed {
        ctl_t          ctl;
        logic          vld1;
        logic          vld2;
        logic [DW-1:0] pipe;
        logic [DW-1:0] dout;
    } state_t;

    state_t st_q, st_d;
    ctl_t   ctl_d;

    sbr_cmd_e         cmd;
    logic [LANES-1:0] wr_lanes;
    logic             wr_req;
    logic             acc_rd;
    logic             acc_wr;
    logic [BURST_W-1:0] seq_lo;
    logic [AW-1:0]    acc_addr;
    logic [DW-1:0]    arr_rdata;
    logic [LANES-1:0] arr_wr;

    sbr_cmd_decode #(.LANES(LANES)) u_dec (
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .step_n     (step_n),
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .cmd        (cmd),
        .wr_lanes   (wr_lanes),
        .wr_req     (wr_req)
    );

    // next burst position and the kind of access made on this edge
    always_comb begin
        ctl_d  = st_q.ctl;
        acc_rd = 1'b0;
        acc_wr = 1'b0;
        unique case (cmd)
            CMD_OPEN_RD: begin
                ctl_d.active = 1'b1;
                ctl_d.base   = addr;
                ctl_d.count  = '0;
                acc_rd       = 1'b1;
            end
            CMD_OPEN_CTL: begin
                ctl_d.active = 1'b1;
                ctl_d.base   = addr;
                ctl_d.count  = '0;
                acc_wr       = wr_req;
                acc_rd       = !wr_req;
            end
            CMD_DROP: begin
                ctl_d.active = 1'b0;
            end
            CMD_STEP: begin
                if (st_q.ctl.active) begin
                    ctl_d.count = st_q.ctl.count + 1'b1;
                    acc_wr      = wr_req;
                    acc_rd      = !wr_req;
                end
            end
            default: begin
                if (st_q.ctl.active) begin
                    acc_wr = wr_req;
                    acc_rd = !wr_req;
                end
            end
        endcase
    end

    sbr_burst_seq #(.BURST_W(BURST_W)) u_seq (
        .start_lo   (ctl_d.base[BURST_W-1:0]),
        .count      (ctl_d.count),
        .interleave (interleave),
        .lo         (seq_lo)
    );

    assign acc_addr = {ctl_d.base[AW-1:BURST_W], seq_lo};
    assign arr_wr   = acc_wr ? wr_lanes : '0;

    sbr_lane_array #(
        .DEPTH  (DEPTH),
        .LANES  (LANES),
        .LANE_W (LANE_BITS)
    ) u_arr (
        .clk      (clk),
        .wr_lanes (arr_wr),
        .addr     (acc_addr),
        .wdata    (wdata),
        .rdata    (arr_rdata)
    );

    // two-register read pipeline; a write drops the pending drive
    always_comb begin
        st_d      = st_q;
        st_d.ctl  = ctl_d;
        st_d.vld1 = acc_rd;
        st_d.vld2 = st_q.vld1 && !acc_wr;
        if (acc_rd) begin
            st_d.pipe = arr_rdata;
        end
        if (st_q.vld1) begin
            st_d.dout = st_q.pipe;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.dout;
    assign rd_drive = st_q.vld2 && !out_en_n;

endmodule

// File: rtl/sbr_burst_sram_chk.sv
module sbr_burst_sram_chk #(
    parameter int unsigned DEPTH   = 1024,
    parameter int unsigned BURST_W = 2,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          proc_stb_n,
    input logic          ctrl_stb_n,
    input logic          step_n,
    input logic          rd_drive,
    input logic          active_q,
    input logic          out_vld,
    input logic          acc_rd,
    input logic          acc_wr,
    input logic [AW-1:0] acc_addr
);

    logic sel_now;
    logic open_idle;
    assign sel_now   = !sel_a_n && sel_b && !sel_c_n;
    assign open_idle = active_q && proc_stb_n && ctrl_stb_n;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_drive && !active_q));

    p_pipe_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd ##1 !acc_wr |=> out_vld);

    p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((!proc_stb_n && !sel_a_n) || !ctrl_stb_n) && !sel_now) |=> !active_q);

    p_proc_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && sel_now) |-> (acc_rd && !acc_wr));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_idle && step_n) |-> $stable(acc_addr));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_idle && !step_n) |->
            (acc_addr[AW-1:BURST_W] == $past(acc_addr[AW-1:BURST_W]))
            && (acc_addr[BURST_W-1:0] != $past(acc_addr[BURST_W-1:0])));

    p_write_mute_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !out_vld);

endmodule

bind sbr_burst_sram sbr_burst_sram_chk #(
    .DEPTH   (DEPTH),
    .BURST_W (BURST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .step_n     (step_n),
    .rd_drive   (rd_drive),
    .active_q   (st_q.ctl.active),
    .out_vld    (st_q.vld2),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr)
);

// File: tb/tb_sbr_burst_sram.sv
`timescale 1ns/1ps
module tb_sbr_burst_sram;

    localparam int unsigned TB_DEPTH = 64;
    localparam int unsigned TB_LANES = 4;
    localparam int unsigned AW = $clog2(TB_DEPTH);
    localparam int unsigned DW = TB_LANES * 9;

    typedef struct packed {
        logic        sa_n;
        logic        sb;
        logic        sc_n;
        logic        ps_n;
        logic        cs_n;
        logic        st_n;
        logic        aw_n;
        logic        lw_n;
        logic [3:0]  ls_n;
        logic [9:0]  a;
        logic [35:0] d;
        logic        chk;
        logic        drv;
        logic [35:0] exp;
        logic [3:0]  req;
    } vec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, step_n = 1'b1;
    logic all_wr_n = 1'b1, lane_wr_n = 1'b1;
    logic [TB_LANES-1:0] lane_sel_n = '1;
    logic out_en_n = 1'b0, interleave = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic rd_drive;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sbr_burst_sram #(.DEPTH(TB_DEPTH), .LANES(TB_LANES), .BURST_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .interleave(interleave), .wdata(wdata),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    // walk: write 010..013 linearly with wrap, proc-strobe reads, hold,
    // blocked strobe, deselect, then a single-lane write at 020
    localparam vec_t TBL [20] = '{
        '{0,1,0, 1,0,1, 0,1,4'hF, 10'h010, 36'h111111111, 1,0,36'h0, 4'd5},   // R5 write open
        '{0,1,0, 1,1,0, 0,1,4'hF, 10'h000, 36'h222222222, 1,0,36'h0, 4'd7},   // R7 step
        '{0,1,0, 1,1,0, 0,1,4'hF, 10'h000, 36'h333333333, 1,0,36'h0, 4'd7},
        '{0,1,0, 1,1,0, 0,1,4'hF, 10'h000, 36'h444444444, 1,0,36'h0, 4'd7},
        '{0,1,0, 1,1,0, 0,1,4'hF, 10'h000, 36'h555555555, 1,0,36'h0, 4'd8},   // R8 wrap to 010
        '{0,1,0, 0,1,1, 0,1,4'hF, 10'h011, 36'hFFFFFFFFF, 1,0,36'h0, 4'd6},   // R6 writes ignored
        '{0,1,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 1,1,36'h222222222, 4'd6},
        '{0,1,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 1,1,36'h333333333, 4'd2},   // R2
        '{0,1,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 1,1,36'h333333333, 4'd7},   // hold repeated 012
        '{0,1,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 1,1,36'h444444444, 4'd7},
        '{1,0,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 1,1,36'h555555555, 4'd8},   // selects ignored
        '{1,0,0, 0,1,1, 1,1,4'hF, 10'h030, 36'h0, 1,1,36'h222222222, 4'd7},   // R4 blocked
        '{0,0,0, 0,1,1, 1,1,4'hF, 10'h030, 36'h0, 1,1,36'h222222222, 4'd4},   // R3 drop
        '{1,0,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 1,0,36'h0, 4'd3},
        '{1,0,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 1,0,36'h0, 4'd3},
        '{0,1,0, 1,0,1, 0,1,4'hF, 10'h020, 36'hAAAAAAAAA, 1,0,36'h0, 4'd10},  // R10 all lanes
        '{0,1,0, 1,0,1, 1,0,4'hD, 10'h020, 36'h0, 1,0,36'h0, 4'd10},          // lane 1 only
        '{0,1,0, 1,0,1, 1,0,4'hF, 10'h020, 36'h0, 1,0,36'h0, 4'd5},           // no lane: read
        '{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 1,1,36'hAAAA800AA, 4'd12},  // R12
        '{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 1,1,36'hAAAA800AA, 4'd10}
    };

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        sel_a_n = v.sa_n; sel_b = v.sb; sel_c_n = v.sc_n;
        proc_stb_n = v.ps_n; ctrl_stb_n = v.cs_n; step_n = v.st_n;
        all_wr_n = v.aw_n; lane_wr_n = v.lw_n; lane_sel_n = v.ls_n;
        addr = v.a[AW-1:0]; wdata = v.d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 drive in reset", {35'd0, rd_drive}, 36'd0);
        rst_n = 1'b1;
        check("R1 drive after reset", {35'd0, rd_drive}, 36'd0);

        for (int i = 0; i < 20; i++) begin
            apply(TBL[i]);
            if (TBL[i].chk) begin
                check($sformatf("R%0d row %0d drive", TBL[i].req, i),
                      {35'd0, rd_drive}, {35'd0, TBL[i].drv});
                if (TBL[i].drv) begin
                    check($sformatf("R%0d row %0d data", TBL[i].req, i),
                          rd_data, TBL[i].exp);
                end
            end
        end

        // R11: write mutes drive; R12 read after write; async output enable
        apply('{0,1,0, 1,0,1, 1,1,4'hF, 10'h010, 36'h0, 0,0,36'h0, 4'd0});
        apply('{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R2 data 010", rd_data, 36'h555555555);
        check("R2 drive", {35'd0, rd_drive}, 36'd1);
        apply('{1,0,0, 1,1,1, 0,1,4'hF, 10'h000, 36'h666666666, 0,0,36'h0, 4'd0});
        check("R11 drive after write", {35'd0, rd_drive}, 36'd0);
        apply('{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R11 drive gap", {35'd0, rd_drive}, 36'd0);
        apply('{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R12 new data 010", rd_data, 36'h666666666);
        out_en_n = 1'b1;
        #1;
        check("R11 oe high", {35'd0, rd_drive}, 36'd0);
        out_en_n = 1'b0;
        #1;
        check("R11 oe low", {35'd0, rd_drive}, 36'd1);

        // R9: interleaved from 011 -> 011,010,013,012
        interleave = 1'b1;
        apply('{0,1,0, 1,0,1, 1,1,4'hF, 10'h011, 36'h0, 0,0,36'h0, 4'd0});
        apply('{1,0,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R9 first", rd_data, 36'h222222222);
        apply('{1,0,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R9 second", rd_data, 36'h666666666);
        apply('{1,0,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R9 third", rd_data, 36'h444444444);
        apply('{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R9 fourth", rd_data, 36'h333333333);
        interleave = 1'b0;

        // R1: reset in mid-burst closes it
        rst_n = 1'b0;
        apply('{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        apply('{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R1 drive under reset", {35'd0, rd_drive}, 36'd0);
        rst_n = 1'b1;
        apply('{1,0,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        apply('{1,0,0, 1,1,0, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        apply('{1,0,0, 1,1,1, 1,1,4'hF, 10'h000, 36'h0, 0,0,36'h0, 4'd0});
        check("R1 no burst after reset", {35'd0, rd_drive}, 36'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule